// File: doc/BRIEF.md
# Effective Address Quadrant Qualifier

This block sits at the front of an address translation path. Each access hands it a 64-bit effective address, a flag saying whether the processor runs in hypervisor mode, the kind of access, and the current partition and process ID register values. The block decides which partition ID and process ID the later table walk must use, or it rejects the address with a segment fault.

The two most significant address bits pick one of four quadrants. Hypervisor mode and guest mode use different tables, and two quadrants are closed to guests. Some addresses are rejected whatever the mode: those with any nonzero bit in the ten-bit field just below the quadrant bits. On a fault, the block reports which kind of segment interrupt is due, from the access type. For data accesses it also captures the faulting address into a held data-address register.

All results are registered. They appear one cycle after an input strobe, together with a one-cycle valid pulse.

Top module: `eaq_qualifier`

## Requirements
- R1: `out_valid` is high for exactly the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R2: If any of effective-address bits 61 down to 52 (LSB-0 numbering) is set, the result is a segment fault with `out_lpid` and `out_pid` both zero, regardless of mode or quadrant.
- R3: The quadrant is `in_ea[63:62]`; the remaining bits below bit 52 never affect the qualified IDs.
- R4: In hypervisor mode (`in_hv`=1), quadrant 0 gives partition 0 with the current process ID, quadrant 1 gives the current partition with the current process ID, quadrant 2 gives the current partition with process 0, and quadrant 3 gives partition 0 with process 0.
- R5: In guest mode (`in_hv`=0), quadrant 0 gives the current partition and current process ID, and quadrant 3 gives the current partition with process 0.
- R6: In guest mode, quadrants 1 and 2 produce a segment fault with both ID outputs zero.
- R7: A fault on an instruction fetch (`in_access`=2'b00) gives `out_kind`=2'd1 (instruction segment) and `out_dar_we`=0, and `out_dar` keeps its previous value.
- R8: A fault on a load (2'b01), a store (2'b10) or the spare code 2'b11, which is treated as a load, gives `out_kind`=2'd2 (data segment) and `out_dar_we`=1, and `out_dar` takes the faulting effective address.
- R9: `out_err_code` is zero on every result.
- R10: After reset all outputs are zero.
- R11: A result without a fault has `out_fault`=0, `out_kind`=2'd0 and `out_dar_we`=0, and `out_dar` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe, one request per cycle |
| in_ea | input | 64 | Effective address |
| in_hv | input | 1 | 1 = hypervisor mode, 0 = guest mode |
| in_access | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| in_lpid | input | 32 | Current partition ID register value |
| in_pid | input | 32 | Current process ID register value |
| out_valid | output | 1 | Result pulse |
| out_lpid | output | 32 | Qualified partition ID |
| out_pid | output | 32 | Qualified process ID |
| out_fault | output | 1 | Segment fault raised |
| out_kind | output | 2 | 0 none, 1 instruction segment, 2 data segment |
| out_dar_we | output | 1 | Data-address register updated by this result |
| out_dar | output | 64 | Held data-address register value |
| out_err_code | output | 32 | Error code reported with the result |

## Verification
Every result is due in the cycle right after its strobe, because one register stage sits between the inputs and the outputs. The driver applies one request at a falling edge and pushes the expected result with the cycle number of that edge. The monitor samples shortly after each later falling edge. It requires `out_valid` exactly one cycle after the push and flags any pulse that has no queued item. Because the data-address register is held, the bench models it as state carried from one result to the next. This lets a fetch fault or a clean access between two data faults show that the register was left alone.

// File: rtl/eaq_pkg.sv
package eaq_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_SPARE = 2'b11
    } access_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_ISEG  = 2'd1,
        KIND_DSEG  = 2'd2,
        KIND_RSVD  = 2'd3
    } seg_kind_e;

    localparam int unsigned QUAD_W     = 2;
    localparam int unsigned RSVD_FIELD = 10;

endpackage

// File: rtl/eaq_range_check.sv
module eaq_range_check #(
    parameter int unsigned FIELD_W = 10
) (
    input  logic [FIELD_W-1:0] field,
    output logic               bad
);
    logic [FIELD_W:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < FIELD_W; i++) begin : g_or
        assign acc[i+1] = acc[i] | field[i];
    end

    assign bad = acc[FIELD_W];
endmodule

// File: rtl/eaq_quadrant_select.sv
module eaq_quadrant_select #(
    parameter int unsigned ID_W = 32
) (
    input  logic [1:0]      quad,
    input  logic            hv,
    input  logic [ID_W-1:0] cur_lpid,
    input  logic [ID_W-1:0] cur_pid,
    output logic [ID_W-1:0] sel_lpid,
    output logic [ID_W-1:0] sel_pid,
    output logic            illegal
);
    always_comb begin
        sel_lpid = '0;
        sel_pid  = '0;
        illegal  = 1'b0;
        if (hv) begin
            unique case (quad)
                2'd0: begin
                    sel_pid = cur_pid;
                end
                2'd1: begin
                    sel_lpid = cur_lpid;
                    sel_pid  = cur_pid;
                end
                2'd2: begin
                    sel_lpid = cur_lpid;
                end
                default: begin
                end
            endcase
        end else begin
            unique case (quad)
                2'd0: begin
                    sel_lpid = cur_lpid;
                    sel_pid  = cur_pid;
                end
                2'd3: begin
                    sel_lpid = cur_lpid;
                end
                default: begin
                    illegal = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/eaq_fault_classify.sv
module eaq_fault_classify
    import eaq_pkg::*;
(
    input  logic       fault,
    input  logic [1:0] access,
    output logic [1:0] kind,
    output logic       dar_we
);
    always_comb begin
        kind   = KIND_NONE;
        dar_we = 1'b0;
        if (fault) begin
            if (access == ACC_FETCH) begin
                kind = KIND_ISEG;
            end else begin
                kind   = KIND_DSEG;
                dar_we = 1'b1;
            end
        end
    end
endmodule

// File: rtl/eaq_qualifier.sv
module eaq_qualifier
    import eaq_pkg::*;
#(
    parameter int unsigned EA_W  = 64,
    parameter int unsigned ID_W  = 32,
    parameter int unsigned ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [EA_W-1:0]  in_ea,
    input  logic             in_hv,
    input  logic [1:0]       in_access,
    input  logic [ID_W-1:0]  in_lpid,
    input  logic [ID_W-1:0]  in_pid,
    output logic             out_valid,
    output logic [ID_W-1:0]  out_lpid,
    output logic [ID_W-1:0]  out_pid,
    output logic             out_fault,
    output logic [1:0]       out_kind,
    output logic             out_dar_we,
    output logic [EA_W-1:0]  out_dar,
    output logic [ERR_W-1:0] out_err_code
);
    localparam int unsigned QUAD_HI = EA_W - 1;
    localparam int unsigned QUAD_LO = EA_W - QUAD_W;
    localparam int unsigned CHK_HI  = QUAD_LO - 1;
    localparam int unsigned CHK_LO  = QUAD_LO - RSVD_FIELD;

    typedef struct packed {
        logic             valid;
        logic [ID_W-1:0]  lpid;
        logic [ID_W-1:0]  pid;
        logic             fault;
        logic [1:0]       kind;
        logic             dar_we;
        logic [EA_W-1:0]  dar;
        logic [ERR_W-1:0] err;
    } result_t;

    result_t state_d, state_q;

    logic            range_bad;
    logic            quad_illegal;
    logic [ID_W-1:0] q_lpid;
    logic [ID_W-1:0] q_pid;
    logic            any_fault;
    logic [1:0]      f_kind;
    logic            f_dar_we;

    eaq_range_check #(
        .FIELD_W (RSVD_FIELD)
    ) u_range (
        .field (in_ea[CHK_HI:CHK_LO]),
        .bad   (range_bad)
    );

    eaq_quadrant_select #(
        .ID_W (ID_W)
    ) u_quad (
        .quad     (in_ea[QUAD_HI:QUAD_LO]),
        .hv       (in_hv),
        .cur_lpid (in_lpid),
        .cur_pid  (in_pid),
        .sel_lpid (q_lpid),
        .sel_pid  (q_pid),
        .illegal  (quad_illegal)
    );

    assign any_fault = range_bad | quad_illegal;

    eaq_fault_classify u_class (
        .fault  (any_fault),
        .access (in_access),
        .kind   (f_kind),
        .dar_we (f_dar_we)
    );

    always_comb begin
        state_d        = state_q;
        state_d.valid  = in_valid;
        state_d.dar_we = 1'b0;
        if (in_valid) begin
            state_d.fault  = any_fault;
            state_d.kind   = f_kind;
            state_d.dar_we = f_dar_we;
            state_d.err    = '0;
            if (any_fault) begin
                state_d.lpid = '0;
                state_d.pid  = '0;
            end else begin
                state_d.lpid = q_lpid;
                state_d.pid  = q_pid;
            end
            if (f_dar_we) begin
                state_d.dar = in_ea;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid    = state_q.valid;
    assign out_lpid     = state_q.lpid;
    assign out_pid      = state_q.pid;
    assign out_fault    = state_q.fault;
    assign out_kind     = state_q.kind;
    assign out_dar_we   = state_q.dar_we;
    assign out_dar      = state_q.dar;
    assign out_err_code = state_q.err;
endmodule

// File: rtl/eaq_qualifier_checker.sv
module eaq_qualifier_checker #(
    parameter int unsigned EA_W  = 64,
    parameter int unsigned ID_W  = 32,
    parameter int unsigned ERR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [EA_W-1:0]  in_ea,
    input logic             in_hv,
    input logic [1:0]       in_access,
    input logic [ID_W-1:0]  in_lpid,
    input logic [ID_W-1:0]  in_pid,
    input logic             out_valid,
    input logic [ID_W-1:0]  out_lpid,
    input logic [ID_W-1:0]  out_pid,
    input logic             out_fault,
    input logic [1:0]       out_kind,
    input logic             out_dar_we,
    input logic [EA_W-1:0]  out_dar,
    input logic [ERR_W-1:0] out_err_code
);
    logic       bits_bad;
    logic [1:0] quad;

    assign bits_bad = |in_ea[EA_W-3:EA_W-12];
    assign quad     = in_ea[EA_W-1:EA_W-2];

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_bad_bits_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bits_bad) |=> (out_fault && out_lpid == '0 && out_pid == '0));

    assert_hv_quad1_ids_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hv && !bits_bad && quad == 2'd1)
        |=> (!out_fault && out_lpid == $past(in_lpid) && out_pid == $past(in_pid)));

    assert_guest_quad3_ids_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hv && !bits_bad && quad == 2'd3)
        |=> (!out_fault && out_lpid == $past(in_lpid) && out_pid == '0));

    assert_guest_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hv && (quad == 2'd1 || quad == 2'd2)) |=> out_fault);

    assert_fetch_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_access == 2'b00 && (bits_bad || (!in_hv && quad[1] != quad[0])))
        |=> (out_kind == 2'd1 && !out_dar_we && $stable(out_dar)));

    assert_data_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_access != 2'b00 && bits_bad)
        |=> (out_kind == 2'd2 && out_dar_we && out_dar == $past(in_ea)));

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_err_code == '0);

    assert_clean_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault) |-> (out_kind == 2'd0 && !out_dar_we && $stable(out_dar)));

    assert_hv_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hv && !bits_bad) |=> !out_fault);
endmodule

bind eaq_qualifier eaq_qualifier_checker #(
    .EA_W  (EA_W),
    .ID_W  (ID_W),
    .ERR_W (ERR_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ea        (in_ea),
    .in_hv        (in_hv),
    .in_access    (in_access),
    .in_lpid      (in_lpid),
    .in_pid       (in_pid),
    .out_valid    (out_valid),
    .out_lpid     (out_lpid),
    .out_pid      (out_pid),
    .out_fault    (out_fault),
    .out_kind     (out_kind),
    .out_dar_we   (out_dar_we),
    .out_dar      (out_dar),
    .out_err_code (out_err_code)
);

// File: tb/eaq_qualifier_test.sv
`timescale 1ns/1ps
module eaq_qualifier_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_ea = '0;
    logic        in_hv = 1'b0;
    logic [1:0]  in_access = 2'b00;
    logic [31:0] in_lpid = '0;
    logic [31:0] in_pid = '0;
    logic        out_valid;
    logic [31:0] out_lpid;
    logic [31:0] out_pid;
    logic        out_fault;
    logic [1:0]  out_kind;
    logic        out_dar_we;
    logic [63:0] out_dar;
    logic [31:0] out_err_code;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          stamp;
        string       tag;
        logic [31:0] lpid;
        logic [31:0] pid;
        logic        fault;
        logic [1:0]  kind;
        logic        dar_we;
        logic [63:0] dar;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] model_dar = '0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    eaq_qualifier uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ea        (in_ea),
        .in_hv        (in_hv),
        .in_access    (in_access),
        .in_lpid      (in_lpid),
        .in_pid       (in_pid),
        .out_valid    (out_valid),
        .out_lpid     (out_lpid),
        .out_pid      (out_pid),
        .out_fault    (out_fault),
        .out_kind     (out_kind),
        .out_dar_we   (out_dar_we),
        .out_dar      (out_dar),
        .out_err_code (out_err_code)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic send(input string tag, input logic [63:0] ea, input logic hv,
                        input logic [1:0] acc, input logic [31:0] lp, input logic [31:0] pd);
        exp_t e;
        logic flt;
        logic [1:0] q;
        @(negedge clk);
        in_valid  = 1'b1;
        in_ea     = ea;
        in_hv     = hv;
        in_access = acc;
        in_lpid   = lp;
        in_pid    = pd;
        q   = ea[63:62];
        flt = (ea[61:52] != 10'd0) || (!hv && (q == 2'd1 || q == 2'd2));
        e.stamp = cyc;
        e.tag   = tag;
        e.fault = flt;
        e.lpid  = '0;
        e.pid   = '0;
        if (!flt) begin
            if (hv) begin
                e.lpid = (q == 2'd1 || q == 2'd2) ? lp : 32'd0;
                e.pid  = (q == 2'd0 || q == 2'd1) ? pd : 32'd0;
            end else begin
                e.lpid = lp;
                e.pid  = (q == 2'd0) ? pd : 32'd0;
            end
        end
        e.kind   = !flt ? 2'd0 : (acc == 2'b00 ? 2'd1 : 2'd2);
        e.dar_we = flt && acc != 2'b00;
        if (e.dar_we) model_dar = ea;
        e.dar = model_dar;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard as results come out
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check("R1 unexpected out_valid", 64'd1, 64'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check({"R1 latency ", e.tag}, 64'(cyc - e.stamp), 64'd1);
                        check({"R2/R4/R5 lpid ", e.tag}, 64'(out_lpid), 64'(e.lpid));
                        check({"R4/R5 pid ", e.tag}, 64'(out_pid), 64'(e.pid));
                        check({"R6 fault ", e.tag}, 64'(out_fault), 64'(e.fault));
                        check({"R7/R8/R11 kind ", e.tag}, 64'(out_kind), 64'(e.kind));
                        check({"R7/R8/R11 dar_we ", e.tag}, 64'(out_dar_we), 64'(e.dar_we));
                        check({"R7/R8 dar ", e.tag}, out_dar, e.dar);
                        check({"R9 err ", e.tag}, 64'(out_err_code), 64'd0);
                    end
                end else if (sb.size() != 0 && sb[0].stamp < cyc) begin
                    exp_t e;
                    e = sb.pop_front();
                    check({"R1 missing out_valid ", e.tag}, 64'd0, 64'd1);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [31:0] LP = 32'h0000_0A51;
    localparam logic [31:0] PD = 32'h0000_7C03;

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid", 64'(out_valid), 64'd0);
        check("R10 out_lpid", 64'(out_lpid), 64'd0);
        check("R10 out_pid", 64'(out_pid), 64'd0);
        check("R10 out_fault", 64'(out_fault), 64'd0);
        check("R10 out_kind", 64'(out_kind), 64'd0);
        check("R10 out_dar", out_dar, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R4 hypervisor quadrants, R3 low bits ignored
        send("R4 hv q0", 64'h0000_0000_1234_5678, 1'b1, 2'b01, LP, PD);
        send("R4 hv q1", 64'h4000_0000_0000_0FFF, 1'b1, 2'b10, LP, PD);
        send("R4 hv q2", 64'h8000_0000_0000_1000, 1'b1, 2'b00, LP, PD);
        send("R4 hv q3", 64'hC00F_FFFF_FFFF_FFFF, 1'b1, 2'b01, LP, PD);
        idle(2);
        // R5 guest legal quadrants
        send("R5 guest q0", 64'h0000_0000_0000_4000, 1'b0, 2'b01, LP, PD);
        send("R5 guest q3", 64'hC000_0000_ABCD_0000, 1'b0, 2'b00, LP, PD);
        // R6 / R8 guest illegal on data access
        send("R6 R8 guest q1 load", 64'h4000_0000_0000_0010, 1'b0, 2'b01, LP, PD);
        send("R6 R8 guest q2 store", 64'h8000_0000_0000_0020, 1'b0, 2'b10, LP, PD);
        // R7 fetch fault leaves dar held
        send("R6 R7 guest q1 fetch", 64'h4000_0000_0000_0030, 1'b0, 2'b00, LP, PD);
        // R11 clean access leaves dar held
        send("R11 clean after fault", 64'h0000_0000_0000_0040, 1'b1, 2'b10, LP, PD);
        idle(1);
        // R2 illegal field edges, any mode
        send("R2 bit52 hv", 64'h0010_0000_0000_0000, 1'b1, 2'b01, LP, PD);
        send("R2 bit61 hv fetch", 64'h2000_0000_0000_0000, 1'b1, 2'b00, LP, PD);
        send("R2 bit56 guest q3", 64'hC100_0000_0000_0000, 1'b0, 2'b11, LP, PD);
        send("R3 bit51 legal", 64'h0008_0000_0000_0000, 1'b1, 2'b01, LP, PD);
        // R8 spare access code
        send("R8 spare code", 64'h8000_0000_0000_0050, 1'b0, 2'b11, 32'hFFFF_FFFF, 32'h1);
        idle(1);
        send("R4 hv q1 wide ids", 64'h4000_0000_0000_0000, 1'b1, 2'b01, 32'hFFFF_FFFF, 32'h8000_0001);
        idle(4);
        check("R1 scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule